// File: doc/BRIEF.md
# Real-Time Clock Interrupt Unit

This block sits beside the time-keeping counters of a real-time clock and turns three kinds of event into one active-low, open-drain interrupt request. The three events are an alarm, a periodic pulse and a rollover of the elapsed-time counter. Each source has an enable bit, a mask bit and a sticky flag. Hardware sets the flag when the enabled source fires. Only a software write clears it. The request line is pulled low while any flag has its mask bit set.

The alarm holds five BCD compare values: seconds, minutes, hours, day and month. On each 10 ms update strobe it compares them with the live clock fields. A compare value of FF hex matches any clock value, so a partial alarm repeats every minute, hour, day and so on. The pulse source picks one of four strobes (10 ms, 100 ms, second, minute) through a one-hot select field. The timer source reacts to a rollover strobe from the elapsed-time counter.

While the chip is in standby, only the alarm may pull the request line. Pulse events are not recorded in standby, and they return when standby ends if the pulse source is still enabled. The time counters themselves are outside this block.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset all three flags read 0, `irqPullLow` is 0, all enables and masks are 0, the rate select is 0 and all five alarm compare values hold FF hex.
- R2: The register map on `wrAddr` is: 0 enables, 1 masks, 2 flags, 3 rate select, 8 to 12 alarm compare values for seconds, minutes, hours, day and month. In the enable, mask and flag registers, bit 0 is the alarm, bit 1 the pulse and bit 2 the timer. With the alarm enabled, a clock edge where `tick10ms` is high and every compare value equals its clock field sets flag bit 0, and the flag is visible after that edge. Writes take effect after their edge, so the compare at a given edge uses the values stored before it.
- R3: An alarm compare value of FF hex matches any value of its clock field.
- R4: The alarm flag is not set when the alarm is disabled, when `tick10ms` is low, or when any compare value other than FF differs from its clock field.
- R5: Rate select bits 0, 1, 2 and 3 pick `tick10ms`, `tick100ms`, `tickSec` and `tickMin`. With the pulse enabled and exactly one select bit set, the selected strobe sets flag bit 1 and the other strobes do not.
- R6: If the rate select holds zero bits or more than one bit, no strobe sets the pulse flag.
- R7: With the timer enabled, `timerRoll` sets flag bit 2. It does so in standby as well.
- R8: Outside standby, `irqPullLow` is 1 exactly when some flag is set together with its mask bit.
- R9: A flag stays set until a write to address 2 carries 0 in that flag's bit. Writing 1 to a flag bit neither sets nor clears it.
- R10: In standby, `irqPullLow` follows only the alarm flag AND the alarm mask, and pulse strobes set no flag. Pulse strobes set the flag again once standby ends.
- R11: If a flag-clearing write and a set event for the same flag fall on one edge, the flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick10ms | input | 1 | One-cycle 10 ms update strobe |
| tick100ms | input | 1 | One-cycle 100 ms strobe |
| tickSec | input | 1 | One-cycle second strobe |
| tickMin | input | 1 | One-cycle minute strobe |
| timerRoll | input | 1 | Elapsed-time counter rollover strobe |
| standby | input | 1 | Standby (power-fail) state |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDay | input | 8 | Current day, BCD |
| curMonth | input | 8 | Current month, BCD |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| irqPullLow | output | 1 | Open-drain enable: 1 pulls the request line low |
| flagsOut | output | 3 | Flags: bit 0 alarm, bit 1 pulse, bit 2 timer |

## Verification
The assertions assume that the rollover strobe and the rate strobes last one cycle and are synchronous to `clk`. They also assume that `standby` changes only at clock edges, so the gating of the request line is never seen mid-cycle. The bench drives every input at the falling edge and holds it through one rising edge. It draws clock fields and compare values from a small set of BCD codes plus FF, so that exact matches, wildcard matches and mismatches all happen often, and it mixes standby, clears and set events on the same edges.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W      = 8;
  localparam int N_FIELDS    = 5;
  localparam int FIELD_IDX_W = $clog2(N_FIELDS);
  localparam int SRC_N       = 3;
  localparam int SRC_ALARM   = 0;
  localparam int SRC_PULSE   = 1;
  localparam int SRC_TIMER   = 2;
  localparam logic [DATA_W-1:0] WILDCARD = '1;

  typedef struct packed {
    logic                   alarmArm;
    logic                   pulseSet;
    logic                   timerSet;
    logic                   flagWr;
    logic [SRC_N-1:0]       keepBits;
    logic                   fieldWr;
    logic [FIELD_IDX_W-1:0] fieldIdx;
    logic [DATA_W-1:0]      fieldData;
  } ctrlStrobes_t;
endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int N_RATES    = 4,
  parameter int ALARM_BASE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [N_RATES-1:0] rateTicks,
  input  logic               tick10ms,
  input  logic               timerRoll,
  input  logic               standby,
  output ctrlStrobes_t       strobes,
  output logic [SRC_N-1:0]   maskQ
);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_RATE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] FIELD_LO  = ADDR_W'(ALARM_BASE);
  localparam logic [ADDR_W-1:0] FIELD_HI  = ADDR_W'(ALARM_BASE + N_FIELDS - 1);

  logic [SRC_N-1:0]   enQ;
  logic [N_RATES-1:0] rateSelQ;
  logic               rateSelValid;
  logic [ADDR_W-1:0]  fieldOfs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= '0;
      maskQ    <= '0;
      rateSelQ <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_EN)   enQ      <= wrData[SRC_N-1:0];
      if (wrAddr == ADDR_MASK) maskQ    <= wrData[SRC_N-1:0];
      if (wrAddr == ADDR_RATE) rateSelQ <= wrData[N_RATES-1:0];
    end
  end

  // exactly one select bit must be set for the pulse source to run
  assign rateSelValid = (rateSelQ != '0) && ((rateSelQ & (rateSelQ - 1'b1)) == '0);
  assign fieldOfs     = wrAddr - FIELD_LO;

  always_comb begin
    strobes           = '0;
    strobes.alarmArm  = enQ[SRC_ALARM] & tick10ms;
    strobes.pulseSet  = enQ[SRC_PULSE] & ~standby & rateSelValid & (|(rateSelQ & rateTicks));
    strobes.timerSet  = enQ[SRC_TIMER] & timerRoll;
    strobes.flagWr    = wrEn && (wrAddr == ADDR_FLAG);
    strobes.keepBits  = wrData[SRC_N-1:0];
    strobes.fieldWr   = wrEn && (wrAddr >= FIELD_LO) && (wrAddr <= FIELD_HI);
    strobes.fieldIdx  = fieldOfs[FIELD_IDX_W-1:0];
    strobes.fieldData = wrData;
  end

  a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_MASK) |=> $stable(maskQ));
  a_r6_rate_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADDR_RATE) |=> $stable(rateSelQ));
endmodule

// File: rtl/rtc_irq_datapath.sv
module rtc_irq_datapath
  import rtc_irq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [SRC_N-1:0]           maskQ,
  input  logic                       standby,
  input  logic [N_FIELDS*DATA_W-1:0] curFields,
  output logic [SRC_N-1:0]           flagQ,
  output logic                       irqPullLow
);
  logic [DATA_W-1:0]   alarmQ [N_FIELDS];
  logic [N_FIELDS-1:0] fieldHit;
  logic [SRC_N-1:0]    setVec;
  logic [SRC_N-1:0]    clrVec;
  logic [SRC_N-1:0]    allowVec;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)
        alarmQ[f] <= WILDCARD;
      else if (strobes.fieldWr && strobes.fieldIdx == FIELD_IDX_W'(f))
        alarmQ[f] <= strobes.fieldData;
    end
    assign fieldHit[f] = (alarmQ[f] == WILDCARD) ||
                         (alarmQ[f] == curFields[f*DATA_W +: DATA_W]);
  end

  always_comb begin
    setVec            = '0;
    setVec[SRC_ALARM] = strobes.alarmArm & (&fieldHit);
    setVec[SRC_PULSE] = strobes.pulseSet;
    setVec[SRC_TIMER] = strobes.timerSet;
    clrVec            = strobes.flagWr ? ~strobes.keepBits : '0;
  end

  for (genvar s = 0; s < SRC_N; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)
        flagQ[s] <= 1'b0;
      else
        flagQ[s] <= (flagQ[s] & ~clrVec[s]) | setVec[s];
    end

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[s] && !(strobes.flagWr && !strobes.keepBits[s])) |=> flagQ[s]);
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      setVec[s] |=> flagQ[s]);
  end

  always_comb begin
    allowVec = '1;
    if (standby) begin
      allowVec            = '0;
      allowVec[SRC_ALARM] = 1'b1;
    end
  end

  assign irqPullLow = |(flagQ & maskQ & allowVec);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqPullLow |-> (|(flagQ & maskQ)));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick10ms,
  input  logic              tick100ms,
  input  logic              tickSec,
  input  logic              tickMin,
  input  logic              timerRoll,
  input  logic              standby,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDay,
  input  logic [DATA_W-1:0] curMonth,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqPullLow,
  output logic [SRC_N-1:0]  flagsOut
);
  localparam int N_RATES = 4;

  ctrlStrobes_t     strobes;
  logic [SRC_N-1:0] maskW;

  rtc_irq_ctrl #(
    .ADDR_W(ADDR_W), .N_RATES(N_RATES), .ALARM_BASE(8)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rateTicks ({tickMin, tickSec, tick100ms, tick10ms}),
    .tick10ms  (tick10ms),
    .timerRoll (timerRoll),
    .standby   (standby),
    .strobes   (strobes),
    .maskQ     (maskW)
  );

  rtc_irq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .maskQ      (maskW),
    .standby    (standby),
    .curFields  ({curMonth, curDay, curHour, curMin, curSec}),
    .flagQ      (flagsOut),
    .irqPullLow (irqPullLow)
  );

  a_r2_alarm_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsOut[SRC_ALARM]) |-> $past(tick10ms));
  a_r7_timer_on_roll: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsOut[SRC_TIMER]) |-> $past(timerRoll));
  a_r10_no_pulse_standby: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsOut[SRC_PULSE]) |-> !$past(standby));
  a_r10_irq_standby: assert property (@(posedge clk) disable iff (!rstN)
    (standby && irqPullLow) |-> (flagsOut[SRC_ALARM] && maskW[SRC_ALARM]));
endmodule

// File: tb/rtc_irq_unit_test.sv
module rtc_irq_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick10ms = 0, tick100ms = 0, tickSec = 0, tickMin = 0, timerRoll = 0, standby = 0;
  logic [7:0] curSec = 0, curMin = 0, curHour = 0, curDay = 0, curMonth = 0;
  logic wrEn = 0;
  logic [3:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic irqPullLow;
  logic [2:0] flagsOut;

  int total = 0, failed = 0;

  logic [2:0] mEn = 0, mMask = 0, mFlags = 0;
  logic [3:0] mSel = 0;
  logic [7:0] mAl [5];
  logic [39:0] curNow = 0;
  logic sbNow = 0;

  always #5 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rstN(rstN), .tick10ms(tick10ms), .tick100ms(tick100ms),
    .tickSec(tickSec), .tickMin(tickMin), .timerRoll(timerRoll), .standby(standby),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .curMonth(curMonth), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqPullLow(irqPullLow), .flagsOut(flagsOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] calcSet(input logic [3:0] t, input logic roll,
                                         input logic sb, input logic [39:0] cur);
    logic [2:0] s;
    logic hit;
    logic [3:0] one;
    s = 0;
    hit = 1'b1;
    for (int f = 0; f < 5; f++)
      if (mAl[f] != 8'hFF && mAl[f] != cur[f*8 +: 8]) hit = 1'b0;
    s[0] = mEn[0] & t[0] & hit;
    one = mSel & (mSel - 4'd1);
    s[1] = mEn[1] & ~sb & (mSel != 0) & (one == 0) & (|(mSel & t));
    s[2] = mEn[2] & roll;
    return s;
  endfunction

  // t bits: 0 = 10 ms, 1 = 100 ms, 2 = second, 3 = minute
  task automatic step(input logic [3:0] t, input logic roll, input logic we,
                      input logic [3:0] a, input logic [7:0] d, input string tag);
    logic [2:0] setV, clrV, allow;
    @(negedge clk);
    {tickMin, tickSec, tick100ms, tick10ms} = t;
    timerRoll = roll;
    standby = sbNow;
    {curMonth, curDay, curHour, curMin, curSec} = curNow;
    wrEn = we; wrAddr = a; wrData = d;
    setV = calcSet(t, roll, sbNow, curNow);
    clrV = (we && a == 4'd2) ? ~d[2:0] : 3'b000;
    mFlags = (mFlags & ~clrV) | setV;
    if (we) begin
      if (a == 4'd0) mEn = d[2:0];
      if (a == 4'd1) mMask = d[2:0];
      if (a == 4'd3) mSel = d[3:0];
      if (a >= 4'd8 && a <= 4'd12) mAl[a - 4'd8] = d;
    end
    allow = sbNow ? 3'b001 : 3'b111;
    @(posedge clk);
    #2;
    check({tag, " flags"}, {5'b0, flagsOut}, {5'b0, mFlags});
    check({tag, " irq"}, {7'b0, irqPullLow}, {7'b0, |(mFlags & mMask & allow)});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(4'b0000, 1'b0, 1'b1, a, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int f = 0; f < 5; f++) mAl[f] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1 reset flags", {5'b0, flagsOut}, 8'h00);
    check("R1 reset irq", {7'b0, irqPullLow}, 8'h00);

    curNow = 40'h05_12_08_15_30;
    wr(4'd0, 8'h07, "R2 enable");
    wr(4'd1, 8'h07, "R8 mask");
    wr(4'd8, 8'h30, "R2 sec"); wr(4'd9, 8'h15, "R2 min");
    wr(4'd10, 8'h09, "R2 hour"); wr(4'd11, 8'h12, "R2 day"); wr(4'd12, 8'h05, "R2 month");
    step(4'b0001, 0, 0, 0, 0, "R4 mismatch");
    wr(4'd10, 8'h08, "R2 hour fix");
    step(4'b0000, 0, 0, 0, 0, "R4 no tick");
    step(4'b0001, 0, 0, 0, 0, "R2 match");
    step(4'b0000, 0, 0, 0, 0, "R9 sticky");
    wr(4'd2, 8'h07, "R9 write one");
    wr(4'd2, 8'h06, "R9 clear");
    step(4'b0000, 0, 0, 0, 0, "R2 once per update");
    wr(4'd0, 8'h06, "R4 disable");
    step(4'b0001, 0, 0, 0, 0, "R4 disabled");
    wr(4'd0, 8'h07, "R2 reenable");
    wr(4'd10, 8'hFF, "R3 wildcard hour");
    curNow = 40'h05_12_23_15_30;
    step(4'b0001, 0, 0, 0, 0, "R3 wildcard");
    wr(4'd2, 8'h06, "R9 clear");

    curNow = 40'h05_12_23_15_00;
    wr(4'd3, 8'h04, "R5 select sec");
    step(4'b0100, 0, 0, 0, 0, "R5 sec");
    wr(4'd2, 8'h05, "R9 clear");
    step(4'b0010, 0, 0, 0, 0, "R5 other strobe");
    wr(4'd3, 8'h02, "R5 select 100ms");
    step(4'b0010, 0, 0, 0, 0, "R5 100ms");
    wr(4'd2, 8'h05, "R9 clear");
    wr(4'd3, 8'h0C, "R6 two bits");
    step(4'b1100, 0, 0, 0, 0, "R6 two bits");
    wr(4'd3, 8'h00, "R6 no bits");
    step(4'b1111, 0, 0, 0, 0, "R6 no bits");
    wr(4'd3, 8'h08, "R5 select min");
    step(4'b1000, 0, 0, 0, 0, "R5 min");
    wr(4'd2, 8'h05, "R9 clear");

    step(4'b0000, 1, 0, 0, 0, "R7 rollover");
    wr(4'd1, 8'h03, "R8 timer masked");
    wr(4'd1, 8'h07, "R8 timer unmasked");
    wr(4'd2, 8'h03, "R9 clear");

    sbNow = 1'b1;
    step(4'b1000, 0, 0, 0, 0, "R10 pulse held");
    step(4'b0000, 1, 0, 0, 0, "R10 timer no irq");
    curNow = 40'h05_12_23_15_30;
    step(4'b0001, 0, 0, 0, 0, "R10 alarm irq");
    wr(4'd2, 8'h06, "R10 alarm cleared");
    sbNow = 1'b0;
    step(4'b0000, 0, 0, 0, 0, "R10 restore");
    step(4'b1000, 0, 0, 0, 0, "R10 pulse resumes");
    step(4'b1000, 0, 1, 4'd2, 8'h00, "R11 set wins");
    wr(4'd2, 8'h00, "R9 clear all");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] t, a;
      logic roll, we;
      logic [7:0] d;
      for (int b = 0; b < 4; b++) t[b] = ($urandom % 4) == 0;
      roll = ($urandom % 8) == 0;
      if (($urandom % 10) == 0) sbNow = ~sbNow;
      for (int f = 0; f < 5; f++) curNow[f*8 +: 8] = 8'($urandom % 2);
      we = ($urandom % 2) == 0;
      a = 4'($urandom % 16);
      d = 8'($urandom);
      if (a >= 4'd8 && a <= 4'd12) d = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom % 2);
      if (a == 4'd3 && ($urandom % 2) == 0) d = 8'(1 << ($urandom % 4));
      step(t, roll, we, a, d, "R8 random");
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule